// File: doc/BRIEF.md
# Atomic Read-Modify-Write Unit

This block carries out one indivisible memory update for the packet-filter instruction set. A caller hands it one atomic instruction: the 8-bit opcode, the 32-bit immediate that picks the operation, the base address register value, the signed 16-bit offset, the source register value and the current R0 value. The unit then runs one sequence on a single-port memory: it reads the target, combines it with the operands, and writes the result back. A lock output stays high for the whole sequence, so an external arbiter keeps other masters off the memory.

The operation comes from the immediate, not from the opcode. Four simple operations are supported: add, or, and, xor. Each has an optional fetch bit that returns the prior memory value. Exchange and compare-exchange always return the prior value. Simple operations and exchange return it to the source register. Compare-exchange returns it to R0. A 32-bit form and a 64-bit form are available. An instruction the unit does not recognise completes with an illegal flag and never touches memory.

When the sequence ends, the unit gives a one-cycle completion pulse. With that pulse come a writeback enable, the target selector and the data. The register file performs the actual register write.

Top module: `atom_rmw_unit`

## Requirements
- R1: Only opcode 0xdb (64-bit) and opcode 0xc3 (32-bit, `mem_word`=1) are accepted. Any other opcode completes with `illegal`=1, without asserting `mem_rd`, `mem_wr` or `lock`.
- R2: The full 32-bit immediate must be one of these values: 0x00/0x01 (add), 0x40/0x41 (or), 0x50/0x51 (and), 0xa0/0xa1 (xor), 0xe1 (exchange), 0xf1 (compare-exchange). Bit 0 is the fetch bit. Any other immediate, including one with any bit above bit 7 set, gives `illegal`=1 and causes no memory access.
- R3: `mem_addr` equals the base value plus the sign-extended offset, with wraparound.
- R4: The simple operations write op(old, src) back to the same address. The result wraps modulo 2^width.
- R5: For a simple operation with the fetch bit set, and for exchange, the completion pulse carries `wb_en`=1, `wb_to_r0`=0 and `wb_data` equal to the old memory value. A simple operation with the fetch bit clear gives `wb_en`=0.
- R6: Exchange stores the source value unchanged.
- R7: Compare-exchange compares R0 with the old memory value at the operation width. It stores the source value only when they are equal, and it always returns the old value with `wb_to_r0`=1.
- R8: A 32-bit operation uses only bits 31:0 of every operand. `mem_wdata[63:32]` is zero, and `wb_data` is the old value zero-extended.
- R9: `lock` rises together with the read request and stays high without a break until the write is acknowledged, or until the compare fails. It is low in the completion cycle. `mem_rd` and `mem_wr` are never high together, and each one holds until `mem_ack`.
- R10: `done` is a single-cycle pulse. A `start` seen while `busy`=1 is ignored.
- R11: During and after reset, `busy`, `done`, `lock`, `mem_rd` and `mem_wr` are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Accept the instruction on the inputs (only when idle) |
| opcode | input | 8 | Instruction opcode |
| imm | input | 32 | Immediate selecting the atomic operation |
| base | input | 64 | Address register value |
| offset | input | 16 | Signed address offset |
| src_val | input | 64 | Source register value |
| r0_val | input | 64 | R0 value (compare operand) |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | Completion pulse |
| illegal | output | 1 | Instruction rejected (valid with done) |
| wb_en | output | 1 | Register writeback requested (valid with done) |
| wb_to_r0 | output | 1 | Writeback target: 1 = R0, 0 = source register |
| wb_data | output | 64 | Old memory value for writeback |
| lock | output | 1 | Memory held for this unit |
| mem_rd | output | 1 | Memory read request |
| mem_wr | output | 1 | Memory write request |
| mem_word | output | 1 | 1 = 32-bit access, 0 = 64-bit access |
| mem_addr | output | 64 | Memory byte address |
| mem_wdata | output | 64 | Write data |
| mem_rdata | input | 64 | Read data, valid with mem_ack during a read |
| mem_ack | input | 1 | Memory completes the current request |

## Verification
The assertions take the following for granted about the memory side:
- `mem_ack` only arrives while a request is pending.
- `mem_rdata` holds the addressed value in the acknowledging cycle of a read.
- Only one request is outstanding at a time.

The bench memory model follows these rules. It answers after a stall of 0 to 3 cycles, keyed off the request signals, and only raises the acknowledge while a request is up. The caller side is also taken to raise `start` only while idle, apart from deliberate pulses during `busy`. The bench places those pulses only in the read phase, so the check of R10 is well defined.

// File: rtl/atom_rmw_pkg.sv
package atom_rmw_pkg;

   localparam logic [7:0] OPC_ATOM_W  = 8'hc3;
   localparam logic [7:0] OPC_ATOM_DW = 8'hdb;

   localparam logic [7:0] IMM_ADD  = 8'h00;
   localparam logic [7:0] IMM_OR   = 8'h40;
   localparam logic [7:0] IMM_AND  = 8'h50;
   localparam logic [7:0] IMM_XOR  = 8'ha0;
   localparam logic [7:0] IMM_XCHG = 8'he1;
   localparam logic [7:0] IMM_CMPX = 8'hf1;

   typedef enum logic [2:0] {
      AOP_ADD, AOP_OR, AOP_AND, AOP_XOR, AOP_XCHG, AOP_CMPX
   } aop_e;

   typedef struct packed {
      logic legal;
      logic word;
      logic fetch;
      aop_e op;
   } adec_t;

   typedef enum logic [2:0] {
      SQ_IDLE, SQ_READ, SQ_MODIFY, SQ_WRITE, SQ_DONE
   } seq_state_e;

endpackage

// File: rtl/atom_decode.sv
module atom_decode
   import atom_rmw_pkg::*;
#(
   parameter int IMM_W = 32
) (
   input  logic [7:0]       opcode,
   input  logic [IMM_W-1:0] imm,
   output adec_t            dec
);

   if (IMM_W < 8) begin : g_bad_imm
      $error("atom_decode: IMM_W must be at least 8");
   end

   logic opc_ok;
   logic imm_ok;
   logic upper_clear;

   if (IMM_W > 8) begin : g_upper
      assign upper_clear = (imm[IMM_W-1:8] == '0);
   end else begin : g_no_upper
      assign upper_clear = 1'b1;
   end

   always_comb begin
      dec       = '0;
      dec.op    = AOP_ADD;
      opc_ok    = 1'b0;
      imm_ok    = upper_clear;
      dec.fetch = imm[0];
      unique case (opcode)
         OPC_ATOM_W:  begin opc_ok = 1'b1; dec.word = 1'b1; end
         OPC_ATOM_DW: begin opc_ok = 1'b1; dec.word = 1'b0; end
         default:     opc_ok = 1'b0;
      endcase
      case (imm[7:0])
         IMM_ADD,  IMM_ADD  | 8'h01: dec.op = AOP_ADD;
         IMM_OR,   IMM_OR   | 8'h01: dec.op = AOP_OR;
         IMM_AND,  IMM_AND  | 8'h01: dec.op = AOP_AND;
         IMM_XOR,  IMM_XOR  | 8'h01: dec.op = AOP_XOR;
         IMM_XCHG:                   dec.op = AOP_XCHG;
         IMM_CMPX:                   dec.op = AOP_CMPX;
         default:                    imm_ok = 1'b0;
      endcase
      dec.legal = opc_ok && imm_ok;
   end

endmodule

// File: rtl/atom_alu.sv
module atom_alu
   import atom_rmw_pkg::*;
#(
   parameter int DATA_W = 64,
   parameter int WORD_W = 32
) (
   input  aop_e              op,
   input  logic              word,
   input  logic [DATA_W-1:0] old_val,
   input  logic [DATA_W-1:0] src_val,
   input  logic [DATA_W-1:0] cmp_val,
   output logic [DATA_W-1:0] new_val,
   output logic [DATA_W-1:0] old_ext,
   output logic              do_write
);

   localparam int HI_W = DATA_W - WORD_W;

   if (HI_W <= 0) begin : g_bad_width
      $error("atom_alu: DATA_W must exceed WORD_W");
   end

   function automatic logic [DATA_W-1:0] fit(input logic w, input logic [DATA_W-1:0] v);
      return w ? {{HI_W{1'b0}}, v[WORD_W-1:0]} : v;
   endfunction

   logic [DATA_W-1:0] a, b, c, raw;

   always_comb begin
      a = fit(word, old_val);
      b = fit(word, src_val);
      c = fit(word, cmp_val);
      unique case (op)
         AOP_ADD:  raw = a + b;
         AOP_OR:   raw = a | b;
         AOP_AND:  raw = a & b;
         AOP_XOR:  raw = a ^ b;
         default:  raw = b;
      endcase
      new_val  = fit(word, raw);
      old_ext  = a;
      do_write = (op != AOP_CMPX) || (a == c);
   end

endmodule

// File: rtl/atom_seq.sv
module atom_seq
   import atom_rmw_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic start,
   input  logic legal,
   input  logic do_write,
   input  logic mem_ack,
   output logic busy,
   output logic lock,
   output logic mem_rd,
   output logic mem_wr,
   output logic cap_req,
   output logic cap_old,
   output logic done
);

   seq_state_e state, nxt;

   always_comb begin
      nxt = state;
      unique case (state)
         SQ_IDLE:   if (start) nxt = legal ? SQ_READ : SQ_DONE;
         SQ_READ:   if (mem_ack) nxt = SQ_MODIFY;
         SQ_MODIFY: nxt = do_write ? SQ_WRITE : SQ_DONE;
         SQ_WRITE:  if (mem_ack) nxt = SQ_DONE;
         default:   nxt = SQ_IDLE;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) state <= SQ_IDLE;
      else        state <= nxt;
   end

   assign busy    = (state != SQ_IDLE);
   assign mem_rd  = (state == SQ_READ);
   assign mem_wr  = (state == SQ_WRITE);
   assign lock    = (state == SQ_READ) || (state == SQ_MODIFY) || (state == SQ_WRITE);
   assign done    = (state == SQ_DONE);
   assign cap_req = (state == SQ_IDLE) && start;
   assign cap_old = (state == SQ_READ) && mem_ack;

   assert_req_locked_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_rd || mem_wr) |-> lock);
   assert_rd_wr_excl_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !(mem_rd && mem_wr));
   assert_rd_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_rd && !mem_ack) |=> mem_rd);
   assert_wr_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_wr && !mem_ack) |=> mem_wr);
   assert_lock_gap_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (lock && !done) |=> (lock || done));

endmodule

// File: rtl/atom_rmw_unit.sv
module atom_rmw_unit
   import atom_rmw_pkg::*;
#(
   parameter int ADDR_W = 64,
   parameter int DATA_W = 64,
   parameter int WORD_W = 32,
   parameter int OFF_W  = 16,
   parameter int IMM_W  = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic [7:0]        opcode,
   input  logic [IMM_W-1:0]  imm,
   input  logic [ADDR_W-1:0] base,
   input  logic [OFF_W-1:0]  offset,
   input  logic [DATA_W-1:0] src_val,
   input  logic [DATA_W-1:0] r0_val,
   output logic              busy,
   output logic              done,
   output logic              illegal,
   output logic              wb_en,
   output logic              wb_to_r0,
   output logic [DATA_W-1:0] wb_data,
   output logic              lock,
   output logic              mem_rd,
   output logic              mem_wr,
   output logic              mem_word,
   output logic [ADDR_W-1:0] mem_addr,
   output logic [DATA_W-1:0] mem_wdata,
   input  logic [DATA_W-1:0] mem_rdata,
   input  logic              mem_ack
);

   localparam int HI_W = DATA_W - WORD_W;

   if (DATA_W != 2 * WORD_W) begin : g_bad_data
      $error("atom_rmw_unit: DATA_W must be twice WORD_W");
   end
   if (OFF_W < 2 || ADDR_W < 8) begin : g_bad_addr
      $error("atom_rmw_unit: address or offset width too small");
   end

   logic [ADDR_W-1:0] off_ext;
   if (OFF_W < ADDR_W) begin : g_sext
      assign off_ext = {{(ADDR_W-OFF_W){offset[OFF_W-1]}}, offset};
   end else begin : g_trunc
      assign off_ext = offset[ADDR_W-1:0];
   end

   adec_t             dec, dec_q;
   logic [ADDR_W-1:0] addr_q;
   logic [DATA_W-1:0] src_q, r0_q, old_q;
   logic [DATA_W-1:0] new_val, old_ext;
   logic              do_write, cap_req, cap_old;

   atom_decode #(.IMM_W(IMM_W)) u_decode (
      .opcode (opcode),
      .imm    (imm),
      .dec    (dec)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         dec_q  <= '0;
         addr_q <= '0;
         src_q  <= '0;
         r0_q   <= '0;
         old_q  <= '0;
      end else begin
         if (cap_req) begin
            dec_q  <= dec;
            addr_q <= base + off_ext;
            src_q  <= src_val;
            r0_q   <= r0_val;
         end
         if (cap_old) old_q <= mem_rdata;
      end
   end

   atom_alu #(.DATA_W(DATA_W), .WORD_W(WORD_W)) u_alu (
      .op       (dec_q.op),
      .word     (dec_q.word),
      .old_val  (old_q),
      .src_val  (src_q),
      .cmp_val  (r0_q),
      .new_val  (new_val),
      .old_ext  (old_ext),
      .do_write (do_write)
   );

   atom_seq u_seq (
      .clk      (clk),
      .rst_n    (rst_n),
      .start    (start),
      .legal    (dec.legal),
      .do_write (do_write),
      .mem_ack  (mem_ack),
      .busy     (busy),
      .lock     (lock),
      .mem_rd   (mem_rd),
      .mem_wr   (mem_wr),
      .cap_req  (cap_req),
      .cap_old  (cap_old),
      .done     (done)
   );

   assign mem_addr  = addr_q;
   assign mem_word  = dec_q.word;
   assign mem_wdata = new_val;
   assign illegal   = done && !dec_q.legal;
   assign wb_en     = done && dec_q.legal && dec_q.fetch;
   assign wb_to_r0  = (dec_q.op == AOP_CMPX);
   assign wb_data   = old_ext;

   assert_access_legal_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_rd || mem_wr) |-> dec_q.legal);
   assert_done_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);
   assert_word_zext_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (wb_en && mem_word) |-> (wb_data[DATA_W-1:WORD_W] == {HI_W{1'b0}}));
   assert_word_wdata_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_wr && mem_word) |-> (mem_wdata[DATA_W-1:WORD_W] == {HI_W{1'b0}}));
   assert_cmpx_match_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_wr && dec_q.op == AOP_CMPX) |-> (old_q[WORD_W-1:0] == r0_q[WORD_W-1:0]));
   assert_req_stable_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (lock && $past(lock)) |-> $stable(mem_addr));

endmodule

// File: tb/atom_rmw_unit_bench.sv
module atom_rmw_unit_bench;

   logic        clk = 1'b0;
   always #4 clk = ~clk;

   logic        rst_n, start;
   logic [7:0]  opcode;
   logic [31:0] imm;
   logic [63:0] base, src_val, r0_val, wb_data, mem_addr, mem_wdata, mem_rdata;
   logic [15:0] offset;
   logic        busy, done, illegal, wb_en, wb_to_r0, lock, mem_rd, mem_wr, mem_word, mem_ack;

   atom_rmw_unit u_atom_rmw_unit (
      .clk(clk), .rst_n(rst_n), .start(start), .opcode(opcode), .imm(imm),
      .base(base), .offset(offset), .src_val(src_val), .r0_val(r0_val),
      .busy(busy), .done(done), .illegal(illegal), .wb_en(wb_en),
      .wb_to_r0(wb_to_r0), .wb_data(wb_data), .lock(lock), .mem_rd(mem_rd),
      .mem_wr(mem_wr), .mem_word(mem_word), .mem_addr(mem_addr),
      .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_ack(mem_ack)
   );

   logic [63:0] mem [8];
   int          stall = 0;
   int          wcnt  = 0;
   logic [2:0]  midx;
   assign midx      = mem_addr[5:3];
   assign mem_ack   = (mem_rd || mem_wr) && (wcnt == stall);
   assign mem_rdata = mem_word ? {32'h0, mem[midx][31:0]} : mem[midx];

   always @(posedge clk) begin
      if ((mem_rd || mem_wr) && !mem_ack) wcnt <= wcnt + 1;
      else                                wcnt <= 0;
      if (mem_wr && mem_ack) begin
         if (mem_word) mem[midx][31:0] <= mem_wdata[31:0];
         else          mem[midx]       <= mem_wdata;
      end
   end

   int nchk = 0;
   int nfail = 0;

   task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
      nchk++;
      if (!ok) begin
         nfail++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic run(input logic [7:0] opc, input logic [31:0] im, input logic [63:0] bs,
                      input logic [15:0] off, input logic [63:0] sv, input logic [63:0] rv,
                      input logic [63:0] init, input int stl);
      logic [63:0] ea, a, b, c, nv, exp_mem;
      bit          word, legal_opc, legal_imm, wr_exp, fetch_exp, to_r0;
      int          nrd, nwr, cyc;
      bit          after_rd, lock_err, hi_err;
      logic [63:0] raddr;
      ea        = bs + {{48{off[15]}}, off};
      word      = (opc == 8'hc3);
      legal_opc = (opc == 8'hc3) || (opc == 8'hdb);
      legal_imm = (im[31:8] == 0) && (im[7:0] inside {8'h00, 8'h01, 8'h40, 8'h41, 8'h50,
                   8'h51, 8'ha0, 8'ha1, 8'he1, 8'hf1});
      mem[ea[5:3]] = init;
      stall = stl;
      a  = word ? {32'h0, init[31:0]} : init;
      b  = word ? {32'h0, sv[31:0]}   : sv;
      c  = word ? {32'h0, rv[31:0]}   : rv;
      case (im[7:4])
         4'h0:    nv = a + b;
         4'h4:    nv = a | b;
         4'h5:    nv = a & b;
         4'ha:    nv = a ^ b;
         default: nv = b;
      endcase
      if (word) nv = {32'h0, nv[31:0]};
      to_r0     = (im[7:0] == 8'hf1);
      wr_exp    = legal_opc && legal_imm && (!to_r0 || (a == c));
      fetch_exp = legal_opc && legal_imm && im[0];
      exp_mem   = !wr_exp ? init : (word ? {init[63:32], nv[31:0]} : nv);

      @(negedge clk);
      start = 1'b1; opcode = opc; imm = im; base = bs; offset = off; src_val = sv; r0_val = rv;
      nrd = 0; nwr = 0; cyc = 0; after_rd = 0; lock_err = 0; hi_err = 0; raddr = '0;
      forever begin
         @(negedge clk);
         cyc++;
         if (cyc == 1 && legal_opc && legal_imm) begin
            // R10: a request while busy must be ignored
            start = 1'b1; opcode = 8'hdb; imm = 32'h0; base = 64'h0; offset = 16'h0;
            src_val = '1; r0_val = '1;
         end else start = 1'b0;
         if ((mem_rd || mem_wr) && !lock) lock_err = 1;
         if (after_rd && !done && !lock) lock_err = 1;
         if (mem_rd && mem_ack) begin nrd++; raddr = mem_addr; after_rd = 1; end
         if (mem_wr && mem_ack) begin
            nwr++;
            if (word && mem_wdata[63:32] != 0) hi_err = 1;
         end
         if (done || cyc > 40) break;
      end
      chk(done, "R10 completion", {63'h0, done}, 64'h1);
      chk(illegal == !(legal_opc && legal_imm), "R1/R2 illegal flag (R1 R2)", {63'h0, illegal},
          {63'h0, !(legal_opc && legal_imm)});
      chk(nrd == ((legal_opc && legal_imm) ? 1 : 0), "R1 R2 read count", 64'(nrd),
          (legal_opc && legal_imm) ? 64'h1 : 64'h0);
      chk(nwr == (wr_exp ? 1 : 0), "R7 R4 write count", 64'(nwr), wr_exp ? 64'h1 : 64'h0);
      chk(!lock_err && !lock, "R9 lock window", {63'h0, lock_err}, 64'h0);
      chk(!hi_err, "R8 upper write data", {63'h0, hi_err}, 64'h0);
      if (legal_opc && legal_imm)
         chk(raddr == ea, "R3 effective address", raddr, ea);
      chk(mem[ea[5:3]] == exp_mem, "R4 R6 R7 memory result", mem[ea[5:3]], exp_mem);
      chk(wb_en == fetch_exp, "R5 writeback enable", {63'h0, wb_en}, {63'h0, fetch_exp});
      if (fetch_exp) begin
         chk(wb_to_r0 == to_r0, "R5 R7 writeback target", {63'h0, wb_to_r0}, {63'h0, to_r0});
         chk(wb_data == a, "R5 R8 writeback data", wb_data, a);
      end
      @(negedge clk);
      chk(!done && !busy, "R10 single pulse", {62'h0, done, busy}, 64'h0);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      nfail++;
      $display("FAIL R10 watchdog actual=hung expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
   end

   initial begin
      rst_n = 1'b0; start = 1'b0; opcode = '0; imm = '0; base = '0; offset = '0;
      src_val = '0; r0_val = '0;
      for (int i = 0; i < 8; i++) mem[i] = '0;
      repeat (3) @(negedge clk);
      // R11: reset state
      chk({busy, done, lock, mem_rd, mem_wr} == 5'b0, "R11 reset outputs",
          {59'h0, busy, done, lock, mem_rd, mem_wr}, 64'h0);
      rst_n = 1'b1;
      @(negedge clk);
      chk({busy, done, lock, mem_rd, mem_wr} == 5'b0, "R11 after reset",
          {59'h0, busy, done, lock, mem_rd, mem_wr}, 64'h0);

      // R1: sweep of every opcode with a fetching add
      for (int o = 0; o < 256; o++)
         run(8'(o), 32'h01, 64'h2048, 16'hfff8, 64'h5, 64'h0, 64'h1234_5678_9abc_def0, o % 3);

      // R2 R4 R5 R6 R8: sweep of every low immediate byte at both widths, two data sets
      for (int p = 0; p < 2; p++)
         for (int w = 0; w < 2; w++)
            for (int k = 0; k < 256; k++)
               run(w ? 8'hc3 : 8'hdb, 32'(k), 64'h2040 + 64'((k % 8) * 8), 16'hffc0,
                   p ? 64'h1 : 64'h0f0f_4321_8000_0001, 64'h0,
                   p ? 64'hffff_ffff_ffff_ffff : 64'hf0f0_1234_8000_ffff, k % 4);

      // R2: bits above bit 7 make the immediate illegal
      run(8'hdb, 32'h0000_0100, 64'h2000, 16'h0, 64'h7, 64'h0, 64'h55, 0);
      run(8'hc3, 32'h8000_0041, 64'h2000, 16'h8, 64'h7, 64'h0, 64'h55, 1);

      // R7: compare-exchange match and mismatch at both widths
      run(8'hdb, 32'hf1, 64'h2000, 16'h10, 64'haaaa_bbbb_cccc_dddd, 64'h1111_2222_3333_4444,
          64'h1111_2222_3333_4444, 2);
      run(8'hdb, 32'hf1, 64'h2000, 16'h10, 64'haaaa_bbbb_cccc_dddd, 64'h1111_2222_3333_4445,
          64'h1111_2222_3333_4444, 1);
      // R7 R8: 32-bit compare looks only at the low half of R0
      run(8'hc3, 32'hf1, 64'h2000, 16'h18, 64'h9999_8888_7777_6666, 64'hdead_beef_0bad_f00d,
          64'hcafe_f00d_0bad_f00d, 3);
      run(8'hc3, 32'hf1, 64'h2000, 16'h18, 64'h9999_8888_7777_6666, 64'h0000_0000_0bad_f00e,
          64'hcafe_f00d_0bad_f00d, 0);

      // R3: positive offset and address wraparound
      run(8'hdb, 32'h01, 64'h2000, 16'h7ff8, 64'h1, 64'h0, 64'h10, 0);
      run(8'hdb, 32'he1, 64'h8, 16'hfff8, 64'h77, 64'h0, 64'h66, 1);

      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
   end

endmodule